// File: doc/BRIEF.md
# Host Status and Interrupt Controller

This block keeps the status, configuration and debug/mode words of a card host controller. Neighbouring command and data-path blocks raise individual status events through a vector of one-cycle set pulses. Software clears those events by writing ones to the status word, and this is the only way a status bit returns to zero. Three of the status events (data-path event, block done, busy done) are combined into one level-sensitive interrupt line.

The configuration word keeps only its implemented enable and mode bits and is presented to the neighbouring blocks. The debug/mode word keeps a 4-bit state code in its low nibble. Software cannot store the code value 0xF (start power-down): a write carrying that code stores 0 in the nibble. All three words can be read back over a simple single-cycle register port. Reads have no side effects. Offsets that are not mapped read as zero.

Top module: `hsi_ctrl`

## Requirements
- R1: After reset the status word is 0, the configuration word is 0, the debug/mode word is 0x0000C60F and the interrupt is low.
- R2: A set pulse on `stat_set[b]`, for an implemented bit b (0, 3..10), makes status bit b read 1 after that clock edge. The bit stays 1 until a clear write removes it.
- R3: A write to the status offset (0x00) clears every status bit whose matching write-data bit (bits 10..0) is 1. All other bits are left unchanged.
- R4: If a set pulse and a clear write hit the same status bit in the same cycle, the bit reads 1 afterwards.
- R5: `irq_o` is high exactly when status bit 8, 9 or 10 is 1. It changes at the same clock edge as the status update that causes it.
- R6: Status bits 0 and 3..7 never raise `irq_o` on their own.
- R7: A write to the configuration offset (0x04) stores bits 0..5, 8 and 10. Configuration bits 6, 7 and 9 always read 0.
- R8: A write to the debug/mode offset (0x08) stores all 32 bits, except that a low nibble of 0xF is stored as 0x0. Any other nibble value is stored unchanged.
- R9: Reads of an unmapped offset return 0. Writes to an unmapped offset change no state.
- R10: Status bits 1 and 2 are reserved. They always read 0, and set pulses on them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr` (combinational, no side effects) |
| stat_set | input | 11 | One-cycle set pulses from the command and data-path blocks |
| stat_o | output | 11 | Current status word |
| cfg_o | output | 11 | Current configuration word |
| mode_o | output | DW (32) | Current debug/mode word |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that:
- status bits are sticky unless a clear write arrives;
- set wins over clear;
- the interrupt follows the three source bits;
- reserved status and configuration bits stay zero;
- a stored state code is never 0xF;
- unmapped accesses read zero and leave the words unchanged.

Only the bench scenarios can show the exact values:
- the reset word;
- which bits a particular clear pattern removes;
- the full 32-bit image stored for a given write.

The bench covers these with a reference model, using both random traffic and directed corner cases.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
    localparam int STAT_W  = 11;
    localparam int CFG_W   = 11;
    localparam int STATE_W = 4;

    // implemented status bits: 0 and 3..10
    localparam logic [STAT_W-1:0] STAT_IMPL = 11'h7F9;
    // status bits feeding the interrupt: 8, 9, 10
    localparam logic [STAT_W-1:0] IRQ_SRC   = 11'h700;
    // implemented configuration bits: 0..5, 8, 10
    localparam logic [CFG_W-1:0]  CFG_IMPL  = 11'h53F;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_CFG,
        SEL_MODE
    } reg_sel_e;
endpackage

// File: rtl/hsi_status_bank.sv
module hsi_status_bank
    import hsi_pkg::*;
#(
    parameter int               W    = STAT_W,
    parameter logic [W-1:0]     IMPL = STAT_IMPL,
    parameter logic [W-1:0]     SRC  = IRQ_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] stat_q,
    output logic         irq_q
);
    logic [W-1:0] clr_eff;
    logic [W-1:0] stat_d;

    // set has priority over clear
    always_comb begin
        clr_eff = clr_we ? clr_bits : '0;
        stat_d  = ((stat_q & ~clr_eff) | set_bits) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= |(stat_d & SRC);
        end
    end
endmodule

// File: rtl/hsi_cfg_reg.sv
module hsi_cfg_reg
    import hsi_pkg::*;
#(
    parameter int           W    = CFG_W,
    parameter logic [W-1:0] IMPL = CFG_IMPL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= '0;
        else if (we) cfg_q <= wdata & IMPL;
    end
endmodule

// File: rtl/hsi_mode_reg.sv
module hsi_mode_reg
    import hsi_pkg::*;
#(
    parameter int            DW  = 32,
    parameter int            SW  = STATE_W,
    parameter logic [DW-1:0] RST = 32'h0000_C60F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode_q
);
    localparam logic [SW-1:0] PD_CODE = {SW{1'b1}};

    logic [DW-1:0] cand;

    always_comb begin
        cand = wdata;
        if (wdata[SW-1:0] == PD_CODE) cand[SW-1:0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  mode_q <= RST;
        else if (we) mode_q <= cand;
    end
endmodule

// File: rtl/hsi_ctrl.sv
module hsi_ctrl
    import hsi_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] OFS_STAT = 8'h00,
    parameter logic [AW-1:0] OFS_CFG  = 8'h04,
    parameter logic [AW-1:0] OFS_MODE = 8'h08,
    parameter logic [DW-1:0] MODE_RST = 32'h0000_C60F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [STAT_W-1:0] stat_set,
    output logic [STAT_W-1:0] stat_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [DW-1:0]     mode_o,
    output logic              irq_o
);
    localparam int PADS = DW - STAT_W;
    localparam int PADC = DW - CFG_W;

    reg_sel_e sel;

    always_comb begin
        if      (bus_addr == OFS_STAT) sel = SEL_STAT;
        else if (bus_addr == OFS_CFG)  sel = SEL_CFG;
        else if (bus_addr == OFS_MODE) sel = SEL_MODE;
        else                           sel = SEL_NONE;
    end

    hsi_status_bank #(.W(STAT_W), .IMPL(STAT_IMPL), .SRC(IRQ_SRC)) i_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (bus_we && sel == SEL_STAT),
        .clr_bits (bus_wdata[STAT_W-1:0]),
        .set_bits (stat_set),
        .stat_q   (stat_o),
        .irq_q    (irq_o)
    );

    hsi_cfg_reg #(.W(CFG_W), .IMPL(CFG_IMPL)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we && sel == SEL_CFG),
        .wdata (bus_wdata[CFG_W-1:0]),
        .cfg_q (cfg_o)
    );

    hsi_mode_reg #(.DW(DW), .SW(STATE_W), .RST(MODE_RST)) i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we && sel == SEL_MODE),
        .wdata  (bus_wdata),
        .mode_q (mode_o)
    );

    always_comb begin
        unique case (sel)
            SEL_STAT: bus_rdata = {{PADS{1'b0}}, stat_o};
            SEL_CFG:  bus_rdata = {{PADC{1'b0}}, cfg_o};
            SEL_MODE: bus_rdata = mode_o;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hsi_ctrl_chk.sv
module hsi_ctrl_chk
    import hsi_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] OFS_STAT = 8'h00,
    parameter logic [AW-1:0] OFS_CFG  = 8'h04,
    parameter logic [AW-1:0] OFS_MODE = 8'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [STAT_W-1:0] stat_set,
    input logic [STAT_W-1:0] stat_o,
    input logic [CFG_W-1:0]  cfg_o,
    input logic [DW-1:0]     mode_o,
    input logic              irq_o
);
    logic wr_stat, unmapped;
    assign wr_stat  = bus_we && bus_addr == OFS_STAT;
    assign unmapped = bus_addr != OFS_STAT && bus_addr != OFS_CFG && bus_addr != OFS_MODE;

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && stat_set == '0) |=> ((stat_o & $past(bus_wdata[STAT_W-1:0])) == '0));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_o & $past(stat_set & STAT_IMPL)) == $past(stat_set & STAT_IMPL)));

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (stat_o[10:8] != 3'b000));

    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_set[10:8] != 3'b000) |=> irq_o);

    assert_cfg_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o & ~CFG_IMPL) == '0);

    assert_no_pd_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_MODE && bus_wdata[STATE_W-1:0] == '1)
        |=> (mode_o[STATE_W-1:0] == '0));

    assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0));

    assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && unmapped && stat_set == '0) |=> ($stable(cfg_o) && $stable(mode_o) && $stable(stat_o)));

    assert_rsvd_stat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[2:1] == 2'b00);
endmodule

bind hsi_ctrl hsi_ctrl_chk #(
    .AW(AW), .DW(DW), .OFS_STAT(OFS_STAT), .OFS_CFG(OFS_CFG), .OFS_MODE(OFS_MODE)
) i_chk (.*);

// File: tb/test_hsi_ctrl.sv
module test_hsi_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] stat_set = '0;
    logic [10:0] stat_o;
    logic [10:0] cfg_o;
    logic [31:0] mode_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [10:0] m_stat;
    logic [10:0] m_cfg;
    logic [31:0] m_mode;

    always #5ns clk = ~clk;

    hsi_ctrl i_hsi_ctrl (.*);

    function automatic logic [10:0] f_stat(logic [10:0] s, logic we, logic [7:0] a,
                                           logic [31:0] wd, logic [10:0] st);
        logic [10:0] c = (we && a == 8'h00) ? wd[10:0] : 11'h0;
        return ((s & ~c) | st) & 11'h7F9;
    endfunction

    function automatic logic [10:0] f_cfg(logic [10:0] c, logic we, logic [7:0] a, logic [31:0] wd);
        return (we && a == 8'h04) ? (wd[10:0] & 11'h53F) : c;
    endfunction

    function automatic logic [31:0] f_mode(logic [31:0] m, logic we, logic [7:0] a, logic [31:0] wd);
        if (!(we && a == 8'h08)) return m;
        return (wd[3:0] == 4'hF) ? {wd[31:4], 4'h0} : wd;
    endfunction

    function automatic logic [31:0] f_read(logic [7:0] a);
        case (a)
            8'h00:   return {21'h0, m_stat};
            8'h04:   return {21'h0, m_cfg};
            8'h08:   return m_mode;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, check read before the edge, outputs after it
    task automatic step(logic we, logic [7:0] a, logic [31:0] wd, logic [10:0] st);
        string rtag;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; stat_set = st;
        #1ns;
        case (a)
            8'h00:   rtag = "R3 read";
            8'h04:   rtag = "R7 read";
            8'h08:   rtag = "R8 read";
            default: rtag = "R9 read";
        endcase
        chk(rtag, bus_rdata, f_read(a));
        @(posedge clk);
        m_stat = f_stat(m_stat, we, a, wd, st);
        m_cfg  = f_cfg(m_cfg, we, a, wd);
        m_mode = f_mode(m_mode, we, a, wd);
        #2ns;
        chk("R2 status", {21'h0, stat_o}, {21'h0, m_stat});
        chk("R5 irq", {31'h0, irq_o}, {31'h0, |m_stat[10:8]});
        chk("R7 cfg", {21'h0, cfg_o}, {21'h0, m_cfg});
        chk("R8 mode", mode_o, m_mode);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] addrs [6];
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'hFC};
        void'($urandom(32'd4711));
        m_stat = '0; m_cfg = '0; m_mode = 32'h0000C60F;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1ns;
        // R1 reset state
        chk("R1 status", {21'h0, stat_o}, 32'h0);
        chk("R1 cfg", {21'h0, cfg_o}, 32'h0);
        chk("R1 mode", mode_o, 32'h0000C60F);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R6: non-interrupt bits set, no irq
        step(0, 8'h00, 0, 11'h0F9);
        chk("R6 irq low", {31'h0, irq_o}, 32'h0);
        // R10: reserved bits ignored
        step(0, 8'h00, 0, 11'h006);
        chk("R10 rsvd", {30'h0, stat_o[2:1]}, 32'h0);
        // R5: busy bit raises irq in the edge of the pulse
        step(0, 8'h00, 0, 11'h400);
        chk("R5 irq high", {31'h0, irq_o}, 32'h1);
        // R4: set and clear same bit
        step(1, 8'h00, 32'h400, 11'h400);
        chk("R4 set wins", {31'h0, stat_o[10]}, 32'h1);
        // R3: clear all
        step(1, 8'h00, 32'hFFFF_FFFF, 0);
        chk("R3 cleared", {21'h0, stat_o}, 32'h0);
        chk("R5 irq drop", {31'h0, irq_o}, 32'h0);
        // R7 config mask
        step(1, 8'h04, 32'hFFFF_FFFF, 0);
        chk("R7 cfg mask", {21'h0, cfg_o}, 32'h53F);
        // R8 power-down code conversion and plain store
        step(1, 8'h08, 32'h1234_567F, 0);
        chk("R8 pd code", mode_o, 32'h1234_5670);
        step(1, 8'h08, 32'hABCD_EF0E, 0);
        chk("R8 plain", mode_o, 32'hABCD_EF0E);
        // R9 unmapped write leaves state
        step(1, 8'h0C, 32'hFFFF_FFFF, 0);
        chk("R9 wr ignored", mode_o, 32'hABCD_EF0E);
        step(0, 8'h10, 0, 0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] wd;
            wd = $urandom;
            if (($urandom % 4) == 0) wd[3:0] = 4'hF;
            step(($urandom % 3) == 0, addrs[$urandom % 6], wd, 11'($urandom & $urandom & $urandom));
        end
        step(0, 8'h00, 0, 0);
        finish_run();
    end
endmodule